// File: doc/BRIEF.md
# Packed 52-bit Multiply-Accumulate Unit

This block is a SIMD integer datapath for wide-integer arithmetic kernels built on 52-bit digits. An input vector is cut into independent 64-bit lanes. In every lane, the low 52 bits of two multiplicand operands are multiplied to a 104-bit unsigned product. One half of that product is then added to a 64-bit unsigned accumulator lane. A select bit, given with each operation, picks either the upper half (bits 103:52) or the lower half (bits 51:0) of the product. The 64-bit sum is returned in the same lane position.

Operations enter through a valid/ready handshake. The unit accepts one vector per cycle and returns each result a fixed three cycles later, flagged by an output valid. The result path has no backpressure. The vector width is a parameter and may be 128, 256 or 512 bits, which gives 2, 4 or 8 lanes. The reset input is asynchronous and active-low, and its release is synchronized inside the block.

Top module: `pmac52_unit`

## Requirements
- R1: In every lane, only multiplicand bits 51:0 take part in the product. Bits 63:52 of both multiplicand lanes have no effect on the result.
- R2: When `op_hi_sel` is 1, the lane result is the accumulator lane plus product bits 103:52, zero-extended to 64 bits.
- R3: When `op_hi_sel` is 0, the lane result is the accumulator lane plus product bits 51:0, zero-extended to 64 bits.
- R4: The lane sum wraps modulo 2^64, and no carry or flag is produced.
- R5: Lanes are independent. Lane i occupies bits 64*i+63:64*i of every vector, and no carry or data crosses a lane boundary.
- R6: `VEC_W` may be 128, 256 or 512, giving VEC_W/64 lanes. With accumulator 10*2^40, multiplicands 11*2^40+4 and 12*2^40+3, every lane returns 11030549757952 for the high select and 100055558127628 for the low select.
- R7: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Its result appears on `out_data` with `out_valid` high exactly three cycles later. Back-to-back operations are accepted on consecutive cycles and come out in order, one per cycle.
- R8: The select bit is captured with each operation and travels with it, so that neighbouring operations with different selects each receive their own variant.
- R9: While reset is active, `out_valid` and `in_ready` are 0. `in_ready` rises a few cycles after reset is released and then stays high.
- R10: Operations still in the pipeline when reset is asserted never produce an `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| op_hi_sel | input | 1 | 1: accumulate upper product half, 0: lower half |
| acc_vec | input | VEC_W | Accumulator lanes |
| mula_vec | input | VEC_W | First multiplicand lanes (bits 51:0 of each lane used) |
| mulb_vec | input | VEC_W | Second multiplicand lanes (bits 51:0 of each lane used) |
| out_valid | output | 1 | Result valid |
| out_data | output | VEC_W | Result lanes |

## Verification
The assertions assume three things: the accumulator and multiplicands are held stable only in the cycle they are accepted, `op_hi_sel` is a known value whenever `in_valid` is high, and reset stays low for at least one full clock cycle. The stimulus drives all inputs one time step after a rising edge. It keeps `in_valid` low until `in_ready` has risen, and it holds reset low for several cycles. Multiplicand patterns fill the ignored top bits with random garbage and include all-ones 52-bit values, so the largest product and the wrap of the sum are both reached without relying on any input restriction.

// File: rtl/pmac52_pkg.sv
package pmac52_pkg;
  localparam int unsigned LANE_W = 64;
  localparam int unsigned MUL_W  = 52;
  localparam int unsigned PROD_W = 2 * MUL_W;
  localparam int unsigned PAD_W  = LANE_W - MUL_W;
  localparam int unsigned STAGES = 3;

  function automatic int unsigned lane_count(int unsigned vec_w);
    return vec_w / LANE_W;
  endfunction

  function automatic bit width_ok(int unsigned vec_w);
    return (vec_w == 128) || (vec_w == 256) || (vec_w == 512);
  endfunction
endpackage

// File: rtl/pmac52_rst_sync.sv
module pmac52_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[DEPTH-1];
endmodule

// File: rtl/pmac52_ctrl.sv
module pmac52_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_hi,
  output logic in_ready,
  output logic en_s1,
  output logic en_s2,
  output logic en_s3,
  output logic hi_s2,
  output logic out_valid
);
  logic ready_q, ready_d;
  logic v1_q, v2_q, v3_q;
  logic v1_d, v2_d, v3_d;
  logic hi1_q, hi2_q;
  logic hi1_d, hi2_d;
  logic fire;

  assign fire = in_valid && ready_q;

  always_comb begin
    ready_d = 1'b1;
    v1_d    = fire;
    v2_d    = v1_q;
    v3_d    = v2_q;
    hi1_d   = fire ? in_hi : hi1_q;
    hi2_d   = v1_q ? hi1_q : hi2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      v1_q    <= 1'b0;
      v2_q    <= 1'b0;
      v3_q    <= 1'b0;
      hi1_q   <= 1'b0;
      hi2_q   <= 1'b0;
    end else begin
      ready_q <= ready_d;
      v1_q    <= v1_d;
      v2_q    <= v2_d;
      v3_q    <= v3_d;
      hi1_q   <= hi1_d;
      hi2_q   <= hi2_d;
    end
  end

  assign in_ready  = ready_q;
  assign en_s1     = fire;
  assign en_s2     = v1_q;
  assign en_s3     = v2_q;
  assign hi_s2     = hi2_q;
  assign out_valid = v3_q;

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(fire, 3));
  // R7
  issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fire, 3) |-> out_valid);
  // R8
  sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v2_q |-> (hi2_q == $past(in_hi, 2)));
  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !in_ready));
  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);
endmodule

// File: rtl/pmac52_lane.sv
module pmac52_lane
  import pmac52_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_s1,
  input  logic              en_s2,
  input  logic              en_s3,
  input  logic              hi_s2,
  input  logic [LANE_W-1:0] acc_i,
  input  logic [LANE_W-1:0] mula_i,
  input  logic [LANE_W-1:0] mulb_i,
  output logic [LANE_W-1:0] res_o
);
  logic [LANE_W-1:0] acc1_q, acc1_d;
  logic [MUL_W-1:0]  ma1_q, ma1_d;
  logic [MUL_W-1:0]  mb1_q, mb1_d;
  logic [LANE_W-1:0] acc2_q, acc2_d;
  logic [PROD_W-1:0] prod2_q, prod2_d;
  logic [LANE_W-1:0] res3_q, res3_d;
  logic [LANE_W-1:0] addend;
  logic              unused_top;

  assign unused_top = ^{mula_i[LANE_W-1:MUL_W], mulb_i[LANE_W-1:MUL_W]};

  // Stage 1: capture accumulator and the 52-bit multiplicand fields
  always_comb begin
    acc1_d = en_s1 ? acc_i : acc1_q;
    ma1_d  = en_s1 ? mula_i[MUL_W-1:0] : ma1_q;
    mb1_d  = en_s1 ? mulb_i[MUL_W-1:0] : mb1_q;
  end

  always_ff @(posedge clk) begin
    acc1_q <= acc1_d;
    ma1_q  <= ma1_d;
    mb1_q  <= mb1_d;
  end

  // Stage 2: full 104-bit product
  always_comb begin
    acc2_d  = en_s2 ? acc1_q : acc2_q;
    prod2_d = en_s2 ? ({{MUL_W{1'b0}}, ma1_q} * {{MUL_W{1'b0}}, mb1_q}) : prod2_q;
  end

  always_ff @(posedge clk) begin
    acc2_q  <= acc2_d;
    prod2_q <= prod2_d;
  end

  // Stage 3: half select and modulo-2^64 accumulate
  always_comb begin
    if (hi_s2) addend = {{PAD_W{1'b0}}, prod2_q[PROD_W-1:MUL_W]};
    else       addend = {{PAD_W{1'b0}}, prod2_q[MUL_W-1:0]};
    res3_d = en_s3 ? (acc2_q + addend) : res3_q;
  end

  always_ff @(posedge clk) begin
    res3_q <= res3_d;
  end

  assign res_o = res3_q;

  // R2 R3 R4: the added amount never exceeds one 52-bit half
  addend_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_s3 |=> ((res_o - $past(acc2_q)) < (64'd1 << MUL_W)));
endmodule

// File: rtl/pmac52_unit.sv
module pmac52_unit
  import pmac52_pkg::*;
#(
  parameter int unsigned VEC_W = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             op_hi_sel,
  input  logic [VEC_W-1:0] acc_vec,
  input  logic [VEC_W-1:0] mula_vec,
  input  logic [VEC_W-1:0] mulb_vec,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_data
);
  localparam int unsigned LANES = lane_count(VEC_W);

  if (!width_ok(VEC_W)) begin : g_bad_width
    $error("pmac52_unit: VEC_W must be 128, 256 or 512");
  end

  logic rst_sync_n;
  logic en_s1, en_s2, en_s3, hi_s2;

  pmac52_rst_sync #(.DEPTH(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pmac52_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .in_hi     (op_hi_sel),
    .in_ready  (in_ready),
    .en_s1     (en_s1),
    .en_s2     (en_s2),
    .en_s3     (en_s3),
    .hi_s2     (hi_s2),
    .out_valid (out_valid)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pmac52_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .en_s1  (en_s1),
      .en_s2  (en_s2),
      .en_s3  (en_s3),
      .hi_s2  (hi_s2),
      .acc_i  (acc_vec [i*LANE_W +: LANE_W]),
      .mula_i (mula_vec[i*LANE_W +: LANE_W]),
      .mulb_i (mulb_vec[i*LANE_W +: LANE_W]),
      .res_o  (out_data[i*LANE_W +: LANE_W])
    );
  end

  // R10
  flush_chk: assert property (@(posedge clk)
    !rst_sync_n |=> !out_valid);
endmodule

// File: tb/pmac52_unit_test.sv
module pmac52_unit_test;
  localparam int unsigned VW = 512;
  localparam int unsigned LN = VW / 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          op_hi_sel = 1'b0;
  logic [VW-1:0] acc_vec = '0;
  logic [VW-1:0] mula_vec = '0;
  logic [VW-1:0] mulb_vec = '0;
  logic          out_valid;
  logic [VW-1:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  typedef struct {
    logic [VW-1:0] data;
    int            due;
    string         tag;
  } exp_t;
  exp_t sb[$];

  pmac52_unit #(.VEC_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_hi_sel(op_hi_sel), .acc_vec(acc_vec), .mula_vec(mula_vec),
    .mulb_vec(mulb_vec), .out_valid(out_valid), .out_data(out_data)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] lane_ref(logic [63:0] a, logic [63:0] b,
                                           logic [63:0] c, logic hi);
    logic [103:0] p;
    p = {52'd0, b[51:0]} * {52'd0, c[51:0]};
    return a + (hi ? {12'd0, p[103:52]} : {12'd0, p[51:0]});
  endfunction

  task automatic check(string tag, logic ok, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: presents one operation and pushes its expected result
  task automatic issue(string tag, logic hi, logic [VW-1:0] a,
                       logic [VW-1:0] b, logic [VW-1:0] c);
    exp_t e;
    @(posedge clk); #1;
    in_valid = 1'b1; op_hi_sel = hi;
    acc_vec = a; mula_vec = b; mulb_vec = c;
    for (int i = 0; i < LN; i++)
      e.data[i*64 +: 64] = lane_ref(a[i*64 +: 64], b[i*64 +: 64], c[i*64 +: 64], hi);
    e.due = cyc + 3;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    @(posedge clk); #1;
    in_valid = 1'b0;
    acc_vec = 'x; mula_vec = 'x; mulb_vec = 'x;
    repeat (n - 1) @(posedge clk);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // Monitor: compares results and latency (R7), flags any stray pulse (R10)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check("R10 unexpected out_valid", 1'b0, out_data, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, out_data === e.data, out_data, e.data);
        check("R7 latency", cyc == e.due, VW'(cyc), VW'(e.due));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check("watchdog timeout", 1'b0, '0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  logic [VW-1:0] va, vb, vc, vexp;

  initial begin
    // R9: reset state
    repeat (4) @(negedge clk);
    check("R9 out_valid in reset", out_valid === 1'b0, VW'(out_valid), '0);
    check("R9 in_ready in reset", in_ready === 1'b0, VW'(in_ready), '0);
    @(posedge clk); #1; rst_n = 1'b1;
    for (int k = 0; k < 10 && !in_ready; k++) @(negedge clk);
    check("R9 in_ready after release", in_ready === 1'b1, VW'(in_ready), VW'(1));

    // R6 R2 R3: check vector on every lane, both selects
    for (int i = 0; i < LN; i++) begin
      va[i*64 +: 64] = 64'd10 << 40;
      vb[i*64 +: 64] = (64'd11 << 40) + 64'd4;
      vc[i*64 +: 64] = (64'd12 << 40) + 64'd3;
    end
    issue("R6 R2 check vector high", 1'b1, va, vb, vc);
    idle(4);
    for (int i = 0; i < LN; i++) vexp[i*64 +: 64] = 64'd11030549757952;
    check("R6 R2 constant high", out_data === vexp, out_data, vexp);
    issue("R6 R3 check vector low", 1'b0, va, vb, vc);
    idle(4);
    for (int i = 0; i < LN; i++) vexp[i*64 +: 64] = 64'd100055558127628;
    check("R6 R3 constant low", out_data === vexp, out_data, vexp);

    // R1: garbage in multiplicand bits 63:52
    for (int i = 0; i < LN; i++) begin
      vb[i*64 +: 64] = {12'hABC ^ 12'(i), vb[i*64 +: 52]};
      vc[i*64 +: 64] = {12'hFFF, vc[i*64 +: 52]};
    end
    issue("R1 top bits ignored high", 1'b1, va, vb, vc);
    issue("R1 top bits ignored low", 1'b0, va, vb, vc);
    idle(4);

    // R4: wrap modulo 2^64; R5: neighbouring lanes keep their own values
    for (int i = 0; i < LN; i++) begin
      va[i*64 +: 64] = (i % 2 == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'd5;
      vb[i*64 +: 64] = (i % 2 == 0) ? 64'd2 : 64'h000F_FFFF_FFFF_FFFF;
      vc[i*64 +: 64] = (i % 2 == 0) ? 64'd1 : 64'h000F_FFFF_FFFF_FFFF;
    end
    issue("R4 R5 wrap low", 1'b0, va, vb, vc);
    idle(4);
    check("R4 lane0 wraps to 1", out_data[63:0] === 64'd1, VW'(out_data[63:0]), VW'(1));
    check("R5 lane1 own value", out_data[127:64] === 64'd6, VW'(out_data[127:64]), VW'(6));
    for (int i = 0; i < LN; i++) va[i*64 +: 64] = 64'hFFFF_FFFF_FFFF_FFFF;
    issue("R4 R5 max product high", 1'b1, va, vb, vc);
    idle(4);

    // R7 R8: back-to-back burst with mixed selects and gaps
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < LN; i++) begin
        va[i*64 +: 64] = rnd64();
        vb[i*64 +: 64] = rnd64();
        vc[i*64 +: 64] = rnd64();
      end
      issue("R7 R8 burst", (n % 3) != 1, va, vb, vc);
      if (n % 11 == 10) idle(2);
    end
    idle(5);
    check("R7 burst drained", sb.size() == 0, VW'(sb.size()), '0);

    // R10: reset while operations are in flight
    issue("R10 dropped a", 1'b1, va, vb, vc);
    issue("R10 dropped b", 1'b0, va, vb, vc);
    @(posedge clk); #1;
    in_valid = 1'b0;
    rst_n = 1'b0;
    sb.delete();
    repeat (3) @(negedge clk);
    check("R10 no output in reset", out_valid === 1'b0, VW'(out_valid), '0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R10 no output after release", out_valid === 1'b0, VW'(out_valid), '0);
    check("R9 ready returns", in_ready === 1'b1, VW'(in_ready), VW'(1));
    issue("R10 post-reset op", 1'b0, va, vb, vc);
    idle(5);
    check("R10 queue empty", sb.size() == 0, VW'(sb.size()), '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule